// File: doc/BRIEF.md
# DMA Configuration Register Port over SPI

This block lets software reach the control and status registers of a descriptor-ring DMA engine over a four-wire SPI link in mode 0. It holds the ring base address, the ring length and the tail pointer. Software writes the tail pointer to submit work. The block also holds an engine enable and an interrupt enable, and it reads back the head pointer and the busy and empty flags that the engine reports. Two events from the engine, ring drained and fetch failure, are latched into sticky status bits. Software clears those bits by writing ones to them. The interrupt line is high while any latched bit is set and the interrupt enable is on.

The SPI pins are resynchronised into the system clock with two-flop synchronisers, and the clock edges are detected in the system clock domain. A transaction is sixteen bits long, MSB first, and is framed by the active-low select. The first byte is `{rw, 4 ignored bits, addr[2:0]}`, where rw = 1 means read. The second byte carries the write data from the master, or the read data that the slave returns on MISO.

Top module: `ring_dma_spi_regs`

## Requirements
- R1: After reset, every writable register reads 0, `spi_miso` is 0, `irq` is 0, and the configuration outputs are 0.
- R2: A write frame to address 0 (base low byte), 1 (base high byte), 2 (ring length) or 3 (tail pointer) stores the data byte. A later read frame returns it, and `ring_base`/`ring_len`/`tail_ptr` reflect it.
- R3: Address 4 keeps only bit 0 (engine enable, driven on `eng_en`) and bit 2 (interrupt enable, driven on `irq_en`). The other bits read back as 0.
- R4: Address 5 reads `hw_head`, and address 6 reads `{6'b0, hw_busy, hw_ring_empty}`. Writes to either address change nothing.
- R5: A rising edge on `evt_ring_empty` sets status bit 0 of address 7, and a rising edge on `evt_fetch_err` sets bit 1. A set bit stays set after the event falls.
- R6: Writing address 7 clears each status bit whose data bit is 1 and leaves the bits written with 0 unchanged.
- R7: `irq` is high exactly when the interrupt enable is set and at least one status bit is set.
- R8: Frames are MSB first. Header bit 7 selects read (1) or write (0), header bits 6:3 are ignored, and header bits 2:0 give the address.
- R9: A frame that ends (select raised) before its sixteenth bit writes nothing.
- R10: `spi_miso` is 0 while the select is high.
- R11: An event held high sets its status bit only once. After a clear, the bit stays clear until the event falls and rises again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sclk | input | 1 | SPI serial clock, idle low |
| spi_mosi | input | 1 | SPI data from master |
| spi_csn | input | 1 | SPI select, active low |
| spi_miso | output | 1 | SPI data to master |
| evt_ring_empty | input | 1 | Engine event: ring drained |
| evt_fetch_err | input | 1 | Engine event: descriptor fetch failed |
| hw_head | input | 8 | Head pointer from the engine |
| hw_busy | input | 1 | Engine has a descriptor in flight |
| hw_ring_empty | input | 1 | Engine reports head equals tail |
| ring_base | output | 16 | Descriptor ring base address |
| ring_len | output | 8 | Ring length in descriptors |
| tail_ptr | output | 8 | Software tail pointer (doorbell) |
| eng_en | output | 1 | Engine enable |
| irq_en | output | 1 | Interrupt enable |
| irq | output | 1 | Consolidated interrupt |

## Verification
A corrupted bit counter or header capture writes to the wrong address or shifts read data by one bit. This shows on the very next read frame as a byte that is rotated or belongs to another register. A status bit that is not sticky, or that is re-set by a held event, shows on `irq` within a few clocks of the event or the clear, well before the next SPI frame completes. Errors in the write enables show at once on the configuration output ports, with no SPI read needed.

// File: rtl/dma_csr_pkg.sv
package dma_csr_pkg;
    localparam int DATA_W     = 8;
    localparam int ADDR_W     = 3;
    localparam int FRAME_BITS = 2 * DATA_W;
    localparam int SYNC_STG   = 2;
    localparam int IRQ_SRC    = 2;
    localparam int CTRL_EN_BIT  = 0;
    localparam int CTRL_IEN_BIT = 2;

    typedef enum logic [ADDR_W-1:0] {
        A_BASE_LO = 3'd0,
        A_BASE_HI = 3'd1,
        A_LEN     = 3'd2,
        A_TAIL    = 3'd3,
        A_CTRL    = 3'd4,
        A_HEAD    = 3'd5,
        A_STAT    = 3'd6,
        A_IRQ_STS = 3'd7
    } csr_addr_e;

    typedef struct packed {
        logic      rd;
        logic [3:0] rsvd;
        csr_addr_e addr;
    } csr_hdr_t;

    function automatic csr_hdr_t hdr_of(input logic [DATA_W-1:0] b);
        return csr_hdr_t'(b);
    endfunction

    function automatic logic [DATA_W-1:0] ctrl_pack(input logic en, input logic ien);
        logic [DATA_W-1:0] v;
        v = '0;
        v[CTRL_EN_BIT]  = en;
        v[CTRL_IEN_BIT] = ien;
        return v;
    endfunction
endpackage

// File: rtl/csr_pin_sync.sv
module csr_pin_sync #(
    parameter int W = 1,
    parameter int STAGES = 2,
    parameter logic [W-1:0] INIT = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] pipe_q;

    always_ff @(posedge clk) begin
        if (rst) pipe_q <= {STAGES{INIT}};
        else     pipe_q <= {pipe_q[STAGES-2:0], d};
    end

    assign q = pipe_q[STAGES-1];
endmodule

// File: rtl/csr_spi_frame.sv
module csr_spi_frame
    import dma_csr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sclk_s,
    input  logic              mosi_s,
    input  logic              csn_s,
    input  logic [DATA_W-1:0] rd_data,
    output csr_addr_e         rd_addr,
    output logic              wr_fire,
    output csr_addr_e         wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              miso
);
    localparam int CNT_W = $clog2(FRAME_BITS + 1);
    localparam logic [CNT_W-1:0] HDR_LAST = CNT_W'(DATA_W - 1);
    localparam logic [CNT_W-1:0] FRM_LAST = CNT_W'(FRAME_BITS - 1);
    localparam logic [CNT_W-1:0] FRM_END  = CNT_W'(FRAME_BITS);
    localparam logic [CNT_W-1:0] DAT_FST  = CNT_W'(DATA_W);

    logic              sclk_prev_q;
    logic              sclk_rise, sclk_fall;
    logic [CNT_W-1:0]  cnt_q;
    logic [DATA_W-1:0] sh_q, tx_q, sh_next;
    logic              hdr_rd_q;
    csr_addr_e         hdr_addr_q;
    logic              hdr_done, frm_done;

    assign sclk_rise = sclk_s & ~sclk_prev_q;
    assign sclk_fall = ~sclk_s & sclk_prev_q;
    assign sh_next   = {sh_q[DATA_W-2:0], mosi_s};
    assign hdr_done  = sclk_rise && (cnt_q == HDR_LAST);
    assign frm_done  = sclk_rise && (cnt_q == FRM_LAST);
    assign rd_addr   = hdr_of(sh_next).addr;

    always_ff @(posedge clk) begin
        if (rst) sclk_prev_q <= 1'b0;
        else     sclk_prev_q <= sclk_s;
    end

    always_ff @(posedge clk) begin
        if (rst || csn_s) begin
            cnt_q      <= '0;
            sh_q       <= '0;
            tx_q       <= '0;
            hdr_rd_q   <= 1'b0;
            hdr_addr_q <= A_BASE_LO;
        end else begin
            if (sclk_rise && cnt_q != FRM_END) begin
                cnt_q <= cnt_q + 1'b1;
                sh_q  <= sh_next;
            end
            if (hdr_done) begin
                hdr_rd_q   <= hdr_of(sh_next).rd;
                hdr_addr_q <= hdr_of(sh_next).addr;
                tx_q       <= hdr_of(sh_next).rd ? rd_data : '0;
            end else if (sclk_fall && cnt_q > DAT_FST) begin
                tx_q <= tx_q << 1;
            end
        end
    end

    assign wr_fire = frm_done && !hdr_rd_q;
    assign wr_addr = hdr_addr_q;
    assign wr_data = sh_next;
    assign miso    = !csn_s && tx_q[DATA_W-1];
endmodule

// File: rtl/csr_irq_status.sv
module csr_irq_status #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] evt,
    input  logic         clr_fire,
    input  logic [N-1:0] clr_mask,
    input  logic         irq_en,
    output logic [N-1:0] sts,
    output logic         irq
);
    logic [N-1:0] evt_q, sts_q, rise, clr;

    assign rise = evt & ~evt_q;
    assign clr  = clr_fire ? clr_mask : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            evt_q <= '0;
            sts_q <= '0;
        end else begin
            evt_q <= evt;
            sts_q <= (sts_q & ~clr) | rise;
        end
    end

    assign sts = sts_q;
    assign irq = irq_en && (|sts_q);
endmodule

// File: rtl/ring_dma_spi_regs.sv
module ring_dma_spi_regs
    import dma_csr_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                spi_sclk,
    input  logic                spi_mosi,
    input  logic                spi_csn,
    output logic                spi_miso,
    input  logic                evt_ring_empty,
    input  logic                evt_fetch_err,
    input  logic [DATA_W-1:0]   hw_head,
    input  logic                hw_busy,
    input  logic                hw_ring_empty,
    output logic [2*DATA_W-1:0] ring_base,
    output logic [DATA_W-1:0]   ring_len,
    output logic [DATA_W-1:0]   tail_ptr,
    output logic                eng_en,
    output logic                irq_en,
    output logic                irq
);
    logic [2:0]         pins_s;
    logic               sclk_s, mosi_s, csn_s;
    csr_addr_e          rd_addr, wr_addr;
    logic [DATA_W-1:0]  rd_data, wr_data;
    logic               wr_fire;
    logic [DATA_W-1:0]  base_lo_q, base_hi_q, len_q, tail_q;
    logic               en_q, ien_q;
    logic [IRQ_SRC-1:0] irq_sts;

    csr_pin_sync #(.W(3), .STAGES(SYNC_STG), .INIT(3'b100)) u_sync (
        .clk(clk), .rst(rst),
        .d({spi_csn, spi_mosi, spi_sclk}),
        .q(pins_s)
    );
    assign {csn_s, mosi_s, sclk_s} = pins_s;

    csr_spi_frame u_frame (
        .clk(clk), .rst(rst),
        .sclk_s(sclk_s), .mosi_s(mosi_s), .csn_s(csn_s),
        .rd_data(rd_data), .rd_addr(rd_addr),
        .wr_fire(wr_fire), .wr_addr(wr_addr), .wr_data(wr_data),
        .miso(spi_miso)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            base_lo_q <= '0;
            base_hi_q <= '0;
            len_q     <= '0;
            tail_q    <= '0;
            en_q      <= 1'b0;
            ien_q     <= 1'b0;
        end else if (wr_fire) begin
            case (wr_addr)
                A_BASE_LO: base_lo_q <= wr_data;
                A_BASE_HI: base_hi_q <= wr_data;
                A_LEN:     len_q     <= wr_data;
                A_TAIL:    tail_q    <= wr_data;
                A_CTRL: begin
                    en_q  <= wr_data[CTRL_EN_BIT];
                    ien_q <= wr_data[CTRL_IEN_BIT];
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        case (rd_addr)
            A_BASE_LO: rd_data = base_lo_q;
            A_BASE_HI: rd_data = base_hi_q;
            A_LEN:     rd_data = len_q;
            A_TAIL:    rd_data = tail_q;
            A_CTRL:    rd_data = ctrl_pack(en_q, ien_q);
            A_HEAD:    rd_data = hw_head;
            A_STAT:    rd_data = {{(DATA_W-2){1'b0}}, hw_busy, hw_ring_empty};
            default:   rd_data = {{(DATA_W-IRQ_SRC){1'b0}}, irq_sts};
        endcase
    end

    csr_irq_status #(.N(IRQ_SRC)) u_irq (
        .clk(clk), .rst(rst),
        .evt({evt_fetch_err, evt_ring_empty}),
        .clr_fire(wr_fire && wr_addr == A_IRQ_STS),
        .clr_mask(wr_data[IRQ_SRC-1:0]),
        .irq_en(ien_q),
        .sts(irq_sts),
        .irq(irq)
    );

    assign ring_base = {base_hi_q, base_lo_q};
    assign ring_len  = len_q;
    assign tail_ptr  = tail_q;
    assign eng_en    = en_q;
    assign irq_en    = ien_q;
endmodule

// File: rtl/ring_dma_spi_regs_chk.sv
module ring_dma_spi_regs_chk (
    input logic       clk,
    input logic       rst,
    input logic       irq,
    input logic       irq_en,
    input logic       evt_ring_empty,
    input logic       evt_fetch_err,
    input logic [1:0] sts,
    input logic       wr_fire,
    input logic [2:0] wr_addr,
    input logic [7:0] wr_data,
    input logic [7:0] tail_ptr,
    input logic       csn_s,
    input logic       miso
);
    p_irq_needs_en_r7: assert property (@(posedge clk) disable iff (rst)
        irq |-> irq_en);

    p_set_empty_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(evt_ring_empty) |=> sts[0]);

    p_set_err_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(evt_fetch_err) |=> sts[1]);

    p_hold_empty_r5: assert property (@(posedge clk) disable iff (rst)
        (sts[0] && !(wr_fire && wr_addr == 3'd7 && wr_data[0])) |=> sts[0]);

    p_clear_err_r6: assert property (@(posedge clk) disable iff (rst)
        (wr_fire && wr_addr == 3'd7 && wr_data[1] && !evt_fetch_err) |=> !sts[1]);

    p_tail_write_only_r9: assert property (@(posedge clk) disable iff (rst)
        !(wr_fire && wr_addr == 3'd3) |=> $stable(tail_ptr));

    p_miso_idle_r10: assert property (@(posedge clk) disable iff (rst)
        csn_s |-> !miso);
endmodule

bind ring_dma_spi_regs ring_dma_spi_regs_chk i_chk (
    .clk(clk), .rst(rst), .irq(irq), .irq_en(irq_en),
    .evt_ring_empty(evt_ring_empty), .evt_fetch_err(evt_fetch_err),
    .sts(irq_sts), .wr_fire(wr_fire), .wr_addr(wr_addr), .wr_data(wr_data),
    .tail_ptr(tail_ptr), .csn_s(csn_s), .miso(spi_miso)
);

// File: tb/test_ring_dma_spi_regs.sv
`timescale 1ns/1ps
module test_ring_dma_spi_regs;
    localparam time HALF = 40ns;

    logic clk = 1'b0, rst = 1'b1;
    logic sclk = 1'b0, mosi = 1'b0, csn = 1'b1;
    logic miso, irq, eng_en, irq_en;
    logic ev_empty = 1'b0, ev_err = 1'b0;
    logic [7:0] hw_head = 8'h00;
    logic hw_busy = 1'b0, hw_empty = 1'b0;
    logic [15:0] ring_base;
    logic [7:0] ring_len, tail_ptr;

    int n_run = 0, n_fail = 0;

    always #5 clk = ~clk;

    ring_dma_spi_regs i_ring_dma_spi_regs (
        .clk(clk), .rst(rst),
        .spi_sclk(sclk), .spi_mosi(mosi), .spi_csn(csn), .spi_miso(miso),
        .evt_ring_empty(ev_empty), .evt_fetch_err(ev_err),
        .hw_head(hw_head), .hw_busy(hw_busy), .hw_ring_empty(hw_empty),
        .ring_base(ring_base), .ring_len(ring_len), .tail_ptr(tail_ptr),
        .eng_en(eng_en), .irq_en(irq_en), .irq(irq)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic xfer(input logic [7:0] hdr, input logic [7:0] wd,
                        input int nbits, output logic [7:0] rd);
        logic [15:0] f;
        f = {hdr, wd};
        rd = '0;
        csn = 1'b0;
        #(HALF);
        for (int i = 15; i > 15 - nbits; i--) begin
            mosi = f[i];
            #(HALF);
            sclk = 1'b1;
            if (i < 8) rd[i] = miso;
            #(HALF);
            sclk = 1'b0;
        end
        #(HALF);
        csn = 1'b1;
        mosi = 1'b0;
        #(2*HALF);
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        logic [7:0] dummy;
        xfer({5'b0, a}, d, 16, dummy);
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        xfer({5'b10000, a}, 8'h00, 16, d);
    endtask

    task automatic pulse_empty();
        ev_empty = 1'b1; #30ns; ev_empty = 1'b0; #30ns;
    endtask

    task automatic pulse_err();
        ev_err = 1'b1; #30ns; ev_err = 1'b0; #30ns;
    endtask

    initial begin
        #1_900_000ns;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] r, v;
        #100ns;
        rst = 1'b0;
        #100ns;

        // R1 reset state
        chk("R1 irq", {15'b0, irq}, 16'h0);
        chk("R1 miso", {15'b0, miso}, 16'h0);
        chk("R1 base", ring_base, 16'h0);
        chk("R1 len/tail", {ring_len, tail_ptr}, 16'h0);
        chk("R1 en", {14'b0, eng_en, irq_en}, 16'h0);
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), r);
            chk("R1 readback", {8'h0, r}, 16'h0);
        end

        // R2 sweep of the four plain registers
        for (int a = 0; a < 4; a++) begin
            for (int k = 0; k < 64; k++) begin
                v = 8'((k * 37 + a * 11 + (k >> 3)) & 8'hFF);
                wr(3'(a), v);
                rd(3'(a), r);
                chk("R2 readback", {8'h0, r}, {8'h0, v});
                case (a)
                    0: chk("R2 base lo", {8'h0, ring_base[7:0]}, {8'h0, v});
                    1: chk("R2 base hi", {8'h0, ring_base[15:8]}, {8'h0, v});
                    2: chk("R2 len", {8'h0, ring_len}, {8'h0, v});
                    default: chk("R2 tail", {8'h0, tail_ptr}, {8'h0, v});
                endcase
            end
        end

        // R3 control keeps bits 0 and 2 only
        for (int k = 0; k < 16; k++) begin
            v = (k < 8) ? 8'(1 << k) : ~8'(1 << (k - 8));
            wr(3'd4, v);
            rd(3'd4, r);
            chk("R3 ctrl readback", {8'h0, r}, {8'h0, v & 8'h05});
            chk("R3 ctrl ports", {14'b0, eng_en, irq_en}, {14'b0, v[0], v[2]});
        end
        wr(3'd4, 8'h00);

        // R4 read-only head and status
        hw_head = 8'hA5; hw_busy = 1'b1; hw_empty = 1'b0;
        #50ns;
        rd(3'd5, r); chk("R4 head", {8'h0, r}, 16'h00A5);
        rd(3'd6, r); chk("R4 stat", {8'h0, r}, 16'h0002);
        wr(3'd5, 8'h3C);
        rd(3'd5, r); chk("R4 head write ignored", {8'h0, r}, 16'h00A5);
        wr(3'd6, 8'hFF);
        hw_busy = 1'b0; hw_empty = 1'b1;
        #50ns;
        rd(3'd6, r); chk("R4 stat write ignored", {8'h0, r}, 16'h0001);

        // R5 sticky set on event edges; R7 gated by enable
        pulse_empty();
        rd(3'd7, r); chk("R5 empty sticky", {8'h0, r}, 16'h0001);
        chk("R7 irq masked", {15'b0, irq}, 16'h0);
        pulse_err();
        rd(3'd7, r); chk("R5 both sticky", {8'h0, r}, 16'h0003);
        wr(3'd4, 8'h04);
        chk("R7 irq enabled", {15'b0, irq}, 16'h1);

        // R6 write-one-to-clear
        wr(3'd7, 8'h00);
        rd(3'd7, r); chk("R6 zero keeps", {8'h0, r}, 16'h0003);
        wr(3'd7, 8'h01);
        rd(3'd7, r); chk("R6 clear bit0", {8'h0, r}, 16'h0002);
        chk("R7 irq still pending", {15'b0, irq}, 16'h1);
        wr(3'd7, 8'hFE);
        rd(3'd7, r); chk("R6 clear bit1", {8'h0, r}, 16'h0000);
        chk("R7 irq dropped", {15'b0, irq}, 16'h0);

        // R11 held event sets once
        ev_err = 1'b1;
        #50ns;
        chk("R11 held sets irq", {15'b0, irq}, 16'h1);
        wr(3'd7, 8'h02);
        rd(3'd7, r); chk("R11 no re-set while held", {8'h0, r}, 16'h0000);
        chk("R11 irq low while held", {15'b0, irq}, 16'h0);
        ev_err = 1'b0;
        #50ns;
        pulse_err();
        rd(3'd7, r); chk("R11 new edge sets", {8'h0, r}, 16'h0002);
        wr(3'd7, 8'h03);

        // R8 reserved header bits ignored, MSB first
        xfer(8'b0111_1010, 8'h5A, 16, r);
        chk("R8 write with rsvd", {8'h0, ring_len}, 16'h005A);
        xfer(8'b1111_1010, 8'h00, 16, r);
        chk("R8 read with rsvd", {8'h0, r}, 16'h005A);
        wr(3'd1, 8'h81);
        rd(3'd1, r); chk("R8 bit order", {8'h0, r}, 16'h0081);

        // R9 truncated frame writes nothing
        wr(3'd3, 8'h42);
        xfer(8'h03, 8'hBD, 12, r);
        chk("R9 tail after short frame", {8'h0, tail_ptr}, 16'h0042);
        xfer(8'h03, 8'hBD, 15, r);
        rd(3'd3, r); chk("R9 tail after 15 bits", {8'h0, r}, 16'h0042);

        // R10 miso idle while deselected
        xfer(8'h81, 8'h00, 12, r);
        chk("R10 miso idle", {15'b0, miso}, 16'h0);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule